// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative translation cache for a 64-bit paged memory system. Each slot keeps a virtual page number, the physical page number it maps to, a permission byte and the address-space identifier (ASID) that was active when the slot was filled. A lookup succeeds only if both the page number and the stored ASID agree with the request page and the ASID now held in the address-translation control word (`satp_i`).

A lookup that misses sends one request to a page-table-walker port and stalls further lookups. The walker's answer fills a slot and is tagged with the ASID current at that moment. The same answer is returned to the requester. A fence pulse clears every slot and ignores its address and ASID operands. A change of the active ASID abandons any walk in flight. A walker answer for an abandoned walk is absorbed without touching the array. Stored slots survive ASID changes. When the mode field is not the translate value, the lookup passes the page number straight through.

Top module: `asid_tlb`

## Requirements
- R1: After reset no slot is valid, `req_ready_o` is 1, and `rsp_valid_o` and `ptw_req_valid_o` are 0.
- R2: When `satp_i[63:60]` is not 8, an accepted lookup gives `rsp_valid_o` in the next cycle. The response carries the zero-extended page number and a permission byte of all ones, and no walk is started.
- R3: When `satp_i[63:60]` is 8 and a lookup misses, `ptw_req_valid_o` is high for exactly one cycle, the cycle after acceptance, with `ptw_req_vpn_o` equal to the missed page. `req_ready_o` stays 0 until the walk ends.
- R4: A walker answer (`ptw_resp_valid_i`) during an active walk fills a slot tagged with the ASID in `satp_i[59:44]` at that cycle. It also yields `rsp_valid_o` in the next cycle with the answer's page and permissions.
- R5: A stored page does not hit when the active ASID differs from the slot's ASID; such a lookup starts a walk.
- R6: A hit returns the stored page and permissions with `rsp_valid_o` in the cycle after acceptance, and starts no walk.
- R7: A `sfence_i` pulse clears every slot, whatever the values on `sfence_vaddr_i` and `sfence_asid_i`.
- R8: A change of the active ASID during a walk abandons it. The next walker answer is dropped: no slot is filled and no response is given. `req_ready_o` returns to 1 after that answer.
- R9: Changing the active ASID does not clear stored slots; a slot filled under one ASID hits again once that ASID is restored.
- R10: A fill uses the lowest-numbered empty slot. When all slots are full, a round-robin pointer, starting at slot 0 after reset and advancing by one per eviction, picks the slot to replace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| satp_i | input | 64 | Translation control word: mode [63:60], ASID [59:44], root page [43:0] |
| sfence_i | input | 1 | Fence pulse: clear all slots |
| sfence_vaddr_i | input | 64 | Fence address operand (ignored) |
| sfence_asid_i | input | 16 | Fence ASID operand (ignored) |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup can be accepted |
| req_vpn_i | input | VPN_W | Lookup virtual page number |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ppn_o | output | PPN_W | Resulting physical page number |
| rsp_perm_o | output | PERM_W | Resulting permission bits |
| ptw_req_valid_o | output | 1 | Walk request pulse |
| ptw_req_vpn_o | output | VPN_W | Page number to walk |
| ptw_resp_valid_i | input | 1 | Walker answer valid |
| ptw_resp_ppn_i | input | PPN_W | Walker physical page number |
| ptw_resp_perm_i | input | PERM_W | Walker permission bits |

## Verification
A hit or a bypassed lookup answers one cycle after acceptance, a miss raises the walk pulse in that same next cycle, and a walker answer produces the response one cycle after it is presented. Every bench task drives inputs on a falling edge and reads outputs on the falling edge that follows the rising edge that consumes them, so each sample lands in the first cycle a result is due. Slot contents, ASID survival and eviction order are observed only through whether a later lookup hits or raises a walk pulse.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
   localparam int unsigned SATP_W        = 64;
   localparam int unsigned MODE_LSB      = 60;
   localparam int unsigned MODE_W        = 4;
   localparam int unsigned ASID_LSB      = 44;
   localparam int unsigned ASID_MAX_W    = 16;
   localparam int unsigned ROOT_W        = 44;
   localparam logic [MODE_W-1:0] MODE_TRANSLATE = 4'h8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WALK  = 2'd1,
      ST_DRAIN = 2'd2
   } walk_state_e;
endpackage

// File: rtl/asid_tlb_array.sv
module asid_tlb_array #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned VPN_W       = 27,
   parameter int unsigned PPN_W       = 44,
   parameter int unsigned PERM_W      = 8,
   parameter int unsigned ASID_W      = 16,
   parameter int unsigned IDX_W       = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   flush_i,
   input  logic [VPN_W-1:0]       lk_vpn_i,
   input  logic [ASID_W-1:0]      lk_asid_i,
   output logic                   lk_hit_o,
   output logic [PPN_W-1:0]       lk_ppn_o,
   output logic [PERM_W-1:0]      lk_perm_o,
   output logic [NUM_ENTRIES-1:0] vld_o,
   input  logic                   wr_en_i,
   input  logic [IDX_W-1:0]       wr_idx_i,
   input  logic [VPN_W-1:0]       wr_vpn_i,
   input  logic [ASID_W-1:0]      wr_asid_i,
   input  logic [PPN_W-1:0]       wr_ppn_i,
   input  logic [PERM_W-1:0]      wr_perm_i
);
   logic [NUM_ENTRIES-1:0] vld_q;
   logic [VPN_W-1:0]       vpn_q  [NUM_ENTRIES];
   logic [ASID_W-1:0]      asid_q [NUM_ENTRIES];
   logic [PPN_W-1:0]       ppn_q  [NUM_ENTRIES];
   logic [PERM_W-1:0]      perm_q [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] match;
   logic                   wr_go;

   assign wr_go = wr_en_i && !flush_i;
   assign vld_o = vld_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || flush_i) begin
         vld_q <= '0;
      end else if (wr_go) begin
         vld_q[wr_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (wr_go) begin
         vpn_q[wr_idx_i]  <= wr_vpn_i;
         asid_q[wr_idx_i] <= wr_asid_i;
         ppn_q[wr_idx_i]  <= wr_ppn_i;
         perm_q[wr_idx_i] <= wr_perm_i;
      end
   end

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i) && (asid_q[g] == lk_asid_i);
   end

   // Slots are unique per (page, ASID), so an OR across matches selects one.
   always_comb begin
      lk_hit_o  = 1'b0;
      lk_ppn_o  = '0;
      lk_perm_o = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         lk_hit_o  = lk_hit_o | match[i];
         lk_ppn_o  = lk_ppn_o  | ({PPN_W{match[i]}}  & ppn_q[i]);
         lk_perm_o = lk_perm_o | ({PERM_W{match[i]}} & perm_q[i]);
      end
   end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned IDX_W       = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_ENTRIES-1:0] vld_i,
   input  logic                   advance_i,
   output logic [IDX_W-1:0]       idx_o
);
   if (NUM_ENTRIES == 1) begin : g_single
      logic unused_victim;
      assign unused_victim = ^{vld_i, advance_i, clk_i, rst_ni};
      assign idx_o = '0;
   end else begin : g_multi
      logic [IDX_W-1:0] rr_q;
      logic [IDX_W-1:0] free_idx;
      logic             all_full;

      assign all_full = &vld_i;

      always_comb begin
         free_idx = '0;
         for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!vld_i[i]) free_idx = IDX_W'(i);
         end
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            rr_q <= '0;
         end else if (advance_i && all_full) begin
            rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
         end
      end

      assign idx_o = all_full ? rr_q : free_idx;
   end
endmodule

// File: rtl/asid_tlb_walk_ctl.sv
module asid_tlb_walk_ctl
   import asid_tlb_pkg::*;
#(
   parameter int unsigned VPN_W = 27
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             miss_i,
   input  logic [VPN_W-1:0] miss_vpn_i,
   input  logic             cancel_i,
   input  logic             resp_valid_i,
   output logic             busy_o,
   output logic             walk_req_o,
   output logic [VPN_W-1:0] walk_vpn_o,
   output logic             refill_o
);
   walk_state_e      state_q;
   logic             req_q;
   logic [VPN_W-1:0] vpn_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         req_q   <= 1'b0;
         vpn_q   <= '0;
      end else begin
         req_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (miss_i) begin
               state_q <= ST_WALK;
               req_q   <= 1'b1;
               vpn_q   <= miss_vpn_i;
            end
            ST_WALK: begin
               if (cancel_i)          state_q <= resp_valid_i ? ST_IDLE : ST_DRAIN;
               else if (resp_valid_i) state_q <= ST_IDLE;
            end
            ST_DRAIN: if (resp_valid_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign walk_req_o = req_q;
   assign walk_vpn_o = vpn_q;
   assign refill_o   = (state_q == ST_WALK) && resp_valid_i && !cancel_i;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import asid_tlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned VPN_W       = 27,
   parameter int unsigned PPN_W       = 44,
   parameter int unsigned PERM_W      = 8,
   parameter int unsigned ASID_W      = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [63:0]       satp_i,
   input  logic              sfence_i,
   input  logic [63:0]       sfence_vaddr_i,
   input  logic [15:0]       sfence_asid_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [VPN_W-1:0]  req_vpn_i,
   output logic              rsp_valid_o,
   output logic [PPN_W-1:0]  rsp_ppn_o,
   output logic [PERM_W-1:0] rsp_perm_o,
   output logic              ptw_req_valid_o,
   output logic [VPN_W-1:0]  ptw_req_vpn_o,
   input  logic              ptw_resp_valid_i,
   input  logic [PPN_W-1:0]  ptw_resp_ppn_i,
   input  logic [PERM_W-1:0] ptw_resp_perm_i
);
   localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

   if (ASID_W < 1 || ASID_W > ASID_MAX_W) begin : g_bad_asid_w
      $error("asid_tlb: ASID_W must lie in 1..16");
   end
   if (PPN_W < VPN_W) begin : g_bad_ppn_w
      $error("asid_tlb: PPN_W must be at least VPN_W for pass-through");
   end
   if (NUM_ENTRIES < 1) begin : g_bad_depth
      $error("asid_tlb: NUM_ENTRIES must be at least 1");
   end

   logic [ASID_W-1:0]      cur_asid;
   logic [ASID_W-1:0]      asid_q;
   logic                   asid_chg;
   logic                   translate;
   logic                   accept;
   logic                   miss;
   logic                   busy;
   logic                   refill;
   logic                   lk_hit;
   logic [PPN_W-1:0]       lk_ppn;
   logic [PERM_W-1:0]      lk_perm;
   logic [NUM_ENTRIES-1:0] vld;
   logic [IDX_W-1:0]       victim;
   logic                   rsp_valid_q;
   logic [PPN_W-1:0]       rsp_ppn_q;
   logic [PERM_W-1:0]      rsp_perm_q;
   logic                   unused_bits;

   assign cur_asid  = satp_i[ASID_LSB +: ASID_W];
   assign translate = (satp_i[MODE_LSB +: MODE_W] == MODE_TRANSLATE);
   assign asid_chg  = (cur_asid != asid_q);
   assign unused_bits = ^{satp_i[ROOT_W-1:0], satp_i[ASID_LSB +: ASID_MAX_W],
                          sfence_vaddr_i, sfence_asid_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) asid_q <= '0;
      else         asid_q <= cur_asid;
   end

   assign req_ready_o = !busy;
   assign accept      = req_valid_i && req_ready_o;
   assign miss        = accept && translate && !lk_hit;

   asid_tlb_array #(
      .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .PERM_W(PERM_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
   ) u_array (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (sfence_i),
      .lk_vpn_i  (req_vpn_i),
      .lk_asid_i (cur_asid),
      .lk_hit_o  (lk_hit),
      .lk_ppn_o  (lk_ppn),
      .lk_perm_o (lk_perm),
      .vld_o     (vld),
      .wr_en_i   (refill),
      .wr_idx_i  (victim),
      .wr_vpn_i  (ptw_req_vpn_o),
      .wr_asid_i (cur_asid),
      .wr_ppn_i  (ptw_resp_ppn_i),
      .wr_perm_i (ptw_resp_perm_i)
   );

   asid_tlb_victim #(
      .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vld_i     (vld),
      .advance_i (refill && !sfence_i),
      .idx_o     (victim)
   );

   asid_tlb_walk_ctl #(
      .VPN_W(VPN_W)
   ) u_walk (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .miss_i       (miss),
      .miss_vpn_i   (req_vpn_i),
      .cancel_i     (asid_chg),
      .resp_valid_i (ptw_resp_valid_i),
      .busy_o       (busy),
      .walk_req_o   (ptw_req_valid_o),
      .walk_vpn_o   (ptw_req_vpn_o),
      .refill_o     (refill)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_ppn_q   <= '0;
         rsp_perm_q  <= '0;
      end else begin
         rsp_valid_q <= refill || (accept && (!translate || lk_hit));
         if (refill) begin
            rsp_ppn_q  <= ptw_resp_ppn_i;
            rsp_perm_q <= ptw_resp_perm_i;
         end else if (accept) begin
            rsp_ppn_q  <= translate ? lk_ppn  : PPN_W'(req_vpn_i);
            rsp_perm_q <= translate ? lk_perm : '1;
         end
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_ppn_o   = rsp_ppn_q;
   assign rsp_perm_o  = rsp_perm_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
   parameter int unsigned VPN_W  = 27,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned ASID_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [63:0]      satp_i,
   input logic             sfence_i,
   input logic             req_valid_i,
   input logic             req_ready_o,
   input logic [VPN_W-1:0] req_vpn_i,
   input logic             rsp_valid_o,
   input logic [PPN_W-1:0] rsp_ppn_o,
   input logic             ptw_req_valid_o,
   input logic [VPN_W-1:0] ptw_req_vpn_o
);
   logic              mode_on;
   logic              taken;
   logic [ASID_W-1:0] asid_now;
   logic [ASID_W-1:0] asid_seen;
   logic              fence_seen;
   logic [VPN_W-1:0]  taken_vpn;
   logic              asid_moved;

   assign mode_on    = (satp_i[63:60] == 4'h8);
   assign taken      = req_valid_i && req_ready_o;
   assign asid_now   = satp_i[44 +: ASID_W];
   assign asid_moved = (asid_now != asid_seen);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         asid_seen  <= '0;
         fence_seen <= 1'b0;
         taken_vpn  <= '0;
      end else begin
         asid_seen  <= asid_now;
         fence_seen <= sfence_i;
         if (taken) taken_vpn <= req_vpn_i;
      end
   end

   p_bare_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken && !mode_on) |=> (rsp_valid_o && !ptw_req_valid_o &&
                               rsp_ppn_o == PPN_W'(taken_vpn)));

   p_walk_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptw_req_valid_o |=> !ptw_req_valid_o);

   p_walk_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptw_req_valid_o |-> (!req_ready_o && ptw_req_vpn_o == taken_vpn));

   p_flush_walks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fence_seen && taken && mode_on) |=> ptw_req_valid_o);

   p_cancel_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (asid_moved && !req_ready_o) |=> !rsp_valid_o);
endmodule

bind asid_tlb asid_tlb_chk #(
   .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .satp_i          (satp_i),
   .sfence_i        (sfence_i),
   .req_valid_i     (req_valid_i),
   .req_ready_o     (req_ready_o),
   .req_vpn_i       (req_vpn_i),
   .rsp_valid_o     (rsp_valid_o),
   .rsp_ppn_o       (rsp_ppn_o),
   .ptw_req_valid_o (ptw_req_valid_o),
   .ptw_req_vpn_o   (ptw_req_vpn_o)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned VPN_W  = 27;
   localparam int unsigned PPN_W  = 44;
   localparam int unsigned PERM_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [63:0]       satp = '0;
   logic              sfence = 1'b0;
   logic [63:0]       sfence_vaddr = '0;
   logic [15:0]       sfence_asid = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [VPN_W-1:0]  req_vpn = '0;
   logic              rsp_valid;
   logic [PPN_W-1:0]  rsp_ppn;
   logic [PERM_W-1:0] rsp_perm;
   logic              ptw_req_valid;
   logic [VPN_W-1:0]  ptw_req_vpn;
   logic              ptw_resp_valid = 1'b0;
   logic [PPN_W-1:0]  ptw_resp_ppn = '0;
   logic [PERM_W-1:0] ptw_resp_perm = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   asid_tlb dut (
      .clk_i(clk), .rst_ni(rst_n), .satp_i(satp), .sfence_i(sfence),
      .sfence_vaddr_i(sfence_vaddr), .sfence_asid_i(sfence_asid),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn),
      .rsp_valid_o(rsp_valid), .rsp_ppn_o(rsp_ppn), .rsp_perm_o(rsp_perm),
      .ptw_req_valid_o(ptw_req_valid), .ptw_req_vpn_o(ptw_req_vpn),
      .ptw_resp_valid_i(ptw_resp_valid), .ptw_resp_ppn_i(ptw_resp_ppn),
      .ptw_resp_perm_i(ptw_resp_perm)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Drive on a falling edge, sample on the falling edge after the consuming rise.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_satp(input logic [3:0] mode, input logic [15:0] asid);
      satp = {mode, asid, 44'h0000_0012_345};
      step();
   endtask

   task automatic lookup(input logic [VPN_W-1:0] vpn);
      req_valid = 1'b1;
      req_vpn   = vpn;
      step();
      req_valid = 1'b0;
   endtask

   task automatic reply(input logic [PPN_W-1:0] ppn, input logic [PERM_W-1:0] perm);
      ptw_resp_valid = 1'b1;
      ptw_resp_ppn   = ppn;
      ptw_resp_perm  = perm;
      step();
      ptw_resp_valid = 1'b0;
   endtask

   task automatic fence(input logic [63:0] va, input logic [15:0] as);
      sfence = 1'b1; sfence_vaddr = va; sfence_asid = as;
      step();
      sfence = 1'b0;
   endtask

   task automatic expect_hit(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                             input string tag);
      lookup(vpn);
      check(rsp_valid && !ptw_req_valid, {tag, " hit without walk"},
            {62'd0, rsp_valid, ptw_req_valid}, 64'h2);
      check(rsp_ppn == ppn, {tag, " hit page"}, 64'(rsp_ppn), 64'(ppn));
   endtask

   task automatic expect_walk(input logic [VPN_W-1:0] vpn, input string tag);
      lookup(vpn);
      check(ptw_req_valid && !rsp_valid && !req_ready, {tag, " miss raises walk"},
            {61'd0, ptw_req_valid, rsp_valid, req_ready}, 64'h4);
      check(ptw_req_vpn == vpn, {tag, " walk page"}, 64'(ptw_req_vpn), 64'(vpn));
   endtask

   task automatic t_reset();
      check(req_ready && !rsp_valid && !ptw_req_valid, "R1 reset outputs",
            {61'd0, req_ready, rsp_valid, ptw_req_valid}, 64'h4);
      expect_walk(27'h10, "R1 empty after reset");
      reply(44'h0, 8'h0);
      fence(64'h0, 16'h0);
   endtask

   task automatic t_bare();
      set_satp(4'h0, 16'h1);
      lookup(27'h123);
      check(rsp_valid && !ptw_req_valid, "R2 bare responds without walk",
            {62'd0, rsp_valid, ptw_req_valid}, 64'h2);
      check(rsp_ppn == 44'h123 && rsp_perm == 8'hFF, "R2 bare page and perms",
            {rsp_perm, 12'd0, rsp_ppn}, {8'hFF, 12'd0, 44'h123});
      set_satp(4'h8, 16'h1);
   endtask

   task automatic t_miss_refill();
      expect_walk(27'h10, "R3");
      reply(44'hABC, 8'h0F);
      check(!ptw_req_valid, "R3 walk pulse one cycle", 64'(ptw_req_valid), 64'h0);
      check(rsp_valid && req_ready, "R4 refill response and ready",
            {62'd0, rsp_valid, req_ready}, 64'h3);
      check(rsp_ppn == 44'hABC && rsp_perm == 8'h0F, "R4 refill data",
            {rsp_perm, 12'd0, rsp_ppn}, {8'h0F, 12'd0, 44'hABC});
      expect_hit(27'h10, 44'hABC, "R6");
      check(rsp_perm == 8'h0F, "R6 hit perms", 64'(rsp_perm), 64'h0F);
   endtask

   task automatic t_asid_mismatch();
      set_satp(4'h8, 16'h2);
      expect_walk(27'h10, "R5 other asid");
      reply(44'hDEF, 8'h07);
      expect_hit(27'h10, 44'hDEF, "R4 tagged with asid 2");
   endtask

   task automatic t_asid_keep();
      set_satp(4'h8, 16'h1);
      expect_hit(27'h10, 44'hABC, "R9 entry kept over asid change");
   endtask

   task automatic t_sfence();
      fence(64'hFFFF_0000_1234_5000, 16'h0005);
      expect_walk(27'h10, "R7 asid1 flushed");
      reply(44'h111, 8'h01);
      set_satp(4'h8, 16'h2);
      expect_walk(27'h10, "R7 asid2 flushed");
      reply(44'h222, 8'h01);
      set_satp(4'h8, 16'h1);
   endtask

   task automatic t_cancel();
      expect_walk(27'h20, "R8 setup");
      satp = {4'h8, 16'h3, 44'h0000_0012_345};
      step();
      check(!req_ready, "R8 stalled while draining", 64'(req_ready), 64'h0);
      reply(44'h555, 8'h03);
      check(!rsp_valid && req_ready, "R8 dropped answer gives no response",
            {62'd0, rsp_valid, req_ready}, 64'h1);
      expect_walk(27'h20, "R8 no refill from dropped answer");
      reply(44'h666, 8'h03);
      check(rsp_valid && rsp_ppn == 44'h666, "R8 later walk completes",
            64'(rsp_ppn), 64'h666);
      set_satp(4'h8, 16'h1);
   endtask

   task automatic t_replace();
      fence(64'h0, 16'h0);
      for (int i = 0; i < 8; i++) begin
         lookup(27'h100 + 27'(i));
         reply(44'h200 + 44'(i), 8'h01);
      end
      expect_hit(27'h100, 44'h200, "R10 all eight held");
      expect_hit(27'h107, 44'h207, "R10 last slot held");
      expect_walk(27'h108, "R10 ninth page");
      reply(44'h208, 8'h01);
      expect_hit(27'h101, 44'h201, "R10 slot1 survives first eviction");
      expect_walk(27'h100, "R10 slot0 evicted first");
      reply(44'h200, 8'h01);
      expect_walk(27'h101, "R10 slot1 evicted second");
      reply(44'h201, 8'h01);
   endtask

   initial begin
      satp = {4'h8, 16'h1, 44'h0000_0012_345};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_bare();
      t_miss_refill();
      t_asid_mismatch();
      t_asid_keep();
      t_sfence();
      t_cancel();
      t_replace();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule